// File: doc/BRIEF.md
# Command Bus Slot Window Limiter

This block sits in front of a memory command bus and decides when each command may issue, so that the bus never carries more command traffic than it can hold. Time after reset is cut into back-to-back windows of `BURST_CYC` clock cycles each, which is the length of one data burst. Each window offers `SLOTS` command slots. A command that holds the bus for more than one clock asks for more than one slot.

A requester presents a command with the earliest cycle at which it would like to issue and the number of slots it needs. In the same cycle the block finds the first window, at or after that cycle, that still has enough free slots, and raises `req_ready`. If the requester holds `req_valid` in that cycle, the slots are reserved and the assigned issue cycle and window number appear on the grant port one clock later. The block tracks a limited span of `HORIZON` windows, starting with the current one. When no window in that span can take the command, `req_ready` stays low and the requester waits.

Top module: `cmd_slot_limiter`

## Requirements
- R1: After reset every tracked window is empty, `grant_valid` is low, and cycle 0 is the first cycle after reset is released.
- R2: Window w covers cycles w*BURST_CYC to (w+1)*BURST_CYC-1, counted from cycle 0. A granted cycle always lies inside the granted window.
- R3: The slots reserved in any window never add up to more than SLOTS.
- R4: The grant names the first window, at or after the effective earliest cycle, whose reserved slots plus the request's cost are at most SLOTS. The issue cycle is the larger of the effective earliest cycle and that window's first cycle.
- R5: An earliest cycle that is already in the past is treated as the current cycle.
- R6: When the window that holds the effective earliest cycle is full, the command goes to the next window. This repeats until a window with room is found.
- R7: A request costs `req_cost` slots. A cost of 0 counts as 1. A cost above SLOTS can never be granted, so `req_ready` stays low for it.
- R8: Only windows from the current one up to the current one plus HORIZON-1 are searched. If none of them fits, `req_ready` is low and nothing is reserved.
- R9: When `req_valid` and `req_ready` are both high at a clock edge, `grant_valid` is high for exactly the following cycle and carries that request's window and issue cycle.
- R10: A reservation accepted in the last cycle of a window is kept without loss or double counting while the window frame moves on at the same edge.
- R11: `req_ready` shows whether a slot is available even while `req_valid` is low. Without `req_valid`, nothing is reserved and no grant appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is presented |
| req_ready | output | 1 | A window with enough room exists for the presented request |
| req_earliest | input | TIME_W | Earliest cycle at which the command may issue |
| req_cost | input | COST_W | Slots the command occupies (0 counts as 1) |
| grant_valid | output | 1 | Grant for the request accepted in the previous cycle |
| grant_cycle | output | TIME_W | Assigned issue cycle |
| grant_window | output | TIME_W | Assigned window number |

## Verification
The assertions check the following on every cycle:
- No window's slot count ever goes above the limit.
- A grant follows exactly those edges where a handshake took place, and no others.
- A granted cycle lies inside its granted window, and is not earlier than either the requested earliest cycle or the cycle of the request.
- The newest window enters the frame empty.

Some behaviours cannot be seen in a single cycle and are shown only by the bench's scenarios, which compare against a reference model kept per absolute window:
- that the chosen window is the first one with room, including deferral across several full windows;
- how far the search horizon reaches;
- how zero-cost and oversized requests are handled;
- that a reservation made right at a window boundary is kept.

// File: rtl/cmd_slot_pkg.sv
package cmd_slot_pkg;
  // Width of absolute cycle and window numbers.
  localparam int unsigned TIME_W = 24;
  typedef logic [TIME_W-1:0] cyc_t;
endpackage

// File: rtl/slot_win_timer.sv
module slot_win_timer
  import cmd_slot_pkg::*;
#(
  parameter int unsigned BURST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output cyc_t now_o,
  output cyc_t win_start_o,
  output cyc_t win_idx_o,
  output logic adv_o
);
  localparam int unsigned PH_W = (BURST_CYC > 1) ? $clog2(BURST_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BURST_CYC - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  cyc_t now_q, now_d, ws_q, ws_d, wi_q, wi_d;
  logic adv;

  always_comb begin
    adv   = (ph_q == PH_LAST);
    now_d = now_q + 1'b1;
    ph_d  = adv ? '0 : ph_q + 1'b1;
    ws_d  = adv ? ws_q + cyc_t'(BURST_CYC) : ws_q;
    wi_d  = adv ? wi_q + 1'b1 : wi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      now_q <= '0;
      ws_q  <= '0;
      wi_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      now_q <= now_d;
      ws_q  <= ws_d;
      wi_q  <= wi_d;
    end
  end

  assign now_o       = now_q;
  assign win_start_o = ws_q;
  assign win_idx_o   = wi_q;
  assign adv_o       = adv;
endmodule

// File: rtl/slot_finder.sv
module slot_finder
  import cmd_slot_pkg::*;
#(
  parameter int unsigned BURST_CYC = 4,
  parameter int unsigned SLOTS     = 3,
  parameter int unsigned HORIZON   = 8,
  parameter int unsigned COST_W    = 3,
  parameter int unsigned CNT_W     = 2
) (
  input  cyc_t                            now_i,
  input  cyc_t                            win_start_i,
  input  cyc_t                            win_idx_i,
  input  logic [HORIZON-1:0][CNT_W-1:0]   cnt_i,
  input  cyc_t                            earliest_i,
  input  logic [COST_W-1:0]               cost_i,
  output logic                            found_o,
  output logic [HORIZON-1:0]              sel_o,
  output cyc_t                            issue_o,
  output cyc_t                            window_o,
  output logic [CNT_W-1:0]                add_o
);
  localparam int unsigned SUM_W = ((CNT_W > COST_W) ? CNT_W : COST_W) + 1;
  localparam int unsigned EW    = TIME_W + 1;
  localparam logic [SUM_W-1:0] CAP = SUM_W'(SLOTS);

  cyc_t               eff;
  logic [SUM_W-1:0]   cost_e;
  logic [HORIZON-1:0] cand;
  cyc_t               lo [HORIZON];

  always_comb begin
    eff    = (earliest_i < now_i) ? now_i : earliest_i;
    cost_e = (cost_i == '0) ? SUM_W'(1) : {{(SUM_W-COST_W){1'b0}}, cost_i};
  end

  // One comparator set per tracked window, evaluated in parallel.
  for (genvar k = 0; k < HORIZON; k++) begin : g_win
    logic [EW-1:0]    hi;
    logic [SUM_W-1:0] tot;
    assign lo[k]   = win_start_i + cyc_t'(k * BURST_CYC);
    assign hi      = {1'b0, win_start_i} + EW'((k + 1) * BURST_CYC);
    assign tot     = {{(SUM_W-CNT_W){1'b0}}, cnt_i[k]} + cost_e;
    assign cand[k] = ({1'b0, eff} < hi) && (tot <= CAP);
  end

  // Lowest-numbered candidate wins.
  always_comb begin
    found_o  = 1'b0;
    sel_o    = '0;
    issue_o  = '0;
    window_o = '0;
    for (int k = 0; k < HORIZON; k++) begin
      if (!found_o && cand[k]) begin
        found_o  = 1'b1;
        sel_o[k] = 1'b1;
        issue_o  = (eff > lo[k]) ? eff : lo[k];
        window_o = win_idx_i + cyc_t'(k);
      end
    end
  end

  assign add_o = CNT_W'(cost_e);
endmodule

// File: rtl/slot_ring.sv
module slot_ring #(
  parameter int unsigned HORIZON = 8,
  parameter int unsigned CNT_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv_i,
  input  logic                          res_en_i,
  input  logic [HORIZON-1:0]            res_sel_i,
  input  logic [CNT_W-1:0]              res_add_i,
  output logic [HORIZON-1:0][CNT_W-1:0] cnt_o
);
  logic [HORIZON-1:0][CNT_W-1:0] cnt_q, cnt_d;

  // On a window advance every entry takes its younger neighbour, and the
  // reservation is steered to where its window lands after the move.
  for (genvar k = 0; k < HORIZON; k++) begin : g_ent
    logic [CNT_W-1:0] keep;
    logic             hit;
    if (k == HORIZON - 1) begin : g_tail
      assign keep = adv_i ? '0 : cnt_q[k];
      assign hit  = res_en_i & ~adv_i & res_sel_i[k];
    end else begin : g_body
      assign keep = adv_i ? cnt_q[k+1] : cnt_q[k];
      assign hit  = res_en_i & (adv_i ? res_sel_i[k+1] : res_sel_i[k]);
    end
    assign cnt_d[k] = hit ? keep + res_add_i : keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cmd_slot_limiter.sv
module cmd_slot_limiter
  import cmd_slot_pkg::*;
#(
  parameter int unsigned BURST_CYC = 4,
  parameter int unsigned SLOTS     = 3,
  parameter int unsigned HORIZON   = 8,
  parameter int unsigned COST_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TIME_W-1:0] req_earliest,
  input  logic [COST_W-1:0] req_cost,
  output logic              grant_valid,
  output logic [TIME_W-1:0] grant_cycle,
  output logic [TIME_W-1:0] grant_window
);
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);

  cyc_t                          now_q, win_start, win_idx;
  logic                          win_adv;
  logic [HORIZON-1:0][CNT_W-1:0] cnt_q;
  logic                          found;
  logic [HORIZON-1:0]            sel;
  cyc_t                          issue, window;
  logic [CNT_W-1:0]              add;
  logic                          fire;

  logic gv_q, gv_d;
  cyc_t gc_q, gc_d, gw_q, gw_d;

  slot_win_timer #(.BURST_CYC(BURST_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .now_o       (now_q),
    .win_start_o (win_start),
    .win_idx_o   (win_idx),
    .adv_o       (win_adv)
  );

  slot_finder #(
    .BURST_CYC (BURST_CYC),
    .SLOTS     (SLOTS),
    .HORIZON   (HORIZON),
    .COST_W    (COST_W),
    .CNT_W     (CNT_W)
  ) u_find (
    .now_i       (now_q),
    .win_start_i (win_start),
    .win_idx_i   (win_idx),
    .cnt_i       (cnt_q),
    .earliest_i  (req_earliest),
    .cost_i      (req_cost),
    .found_o     (found),
    .sel_o       (sel),
    .issue_o     (issue),
    .window_o    (window),
    .add_o       (add)
  );

  slot_ring #(.HORIZON(HORIZON), .CNT_W(CNT_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (win_adv),
    .res_en_i  (fire),
    .res_sel_i (sel),
    .res_add_i (add),
    .cnt_o     (cnt_q)
  );

  assign req_ready = found;
  assign fire      = req_valid & found;

  always_comb begin
    gv_d = fire;
    gc_d = gc_q;
    gw_d = gw_q;
    if (fire) begin
      gc_d = issue;
      gw_d = window;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q <= 1'b0;
      gc_q <= '0;
      gw_q <= '0;
    end else begin
      gv_q <= gv_d;
      gc_q <= gc_d;
      gw_q <= gw_d;
    end
  end

  assign grant_valid  = gv_q;
  assign grant_cycle  = gc_q;
  assign grant_window = gw_q;
endmodule

// File: rtl/slot_limiter_chk.sv
module slot_limiter_chk
  import cmd_slot_pkg::*;
#(
  parameter int unsigned BURST_CYC = 4,
  parameter int unsigned SLOTS     = 3,
  parameter int unsigned HORIZON   = 8,
  parameter int unsigned CNT_W     = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input cyc_t                          req_earliest,
  input logic                          grant_valid,
  input cyc_t                          grant_cycle,
  input cyc_t                          grant_window,
  input cyc_t                          now_i,
  input logic                          adv_i,
  input logic [HORIZON-1:0][CNT_W-1:0] cnt_i
);
  localparam int unsigned EW = TIME_W + 8;

  logic [EW-1:0] gc_e, wlo, whi;
  assign gc_e = EW'(grant_cycle);
  assign wlo  = EW'(grant_window) * EW'(BURST_CYC);
  assign whi  = wlo + EW'(BURST_CYC);

  function automatic logic any_over(input logic [HORIZON-1:0][CNT_W-1:0] c);
    logic r;
    r = 1'b0;
    for (int k = 0; k < HORIZON; k++)
      if (c[k] > CNT_W'(SLOTS)) r = 1'b1;
    return r;
  endfunction

  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_over(cnt_i));

  p_grant_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> grant_valid);

  p_no_spurious_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !grant_valid);

  p_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (grant_cycle >= $past(req_earliest)));

  p_not_past_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (grant_cycle >= $past(now_i)));

  p_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (gc_e >= wlo && gc_e < whi));

  p_tail_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (cnt_i[HORIZON-1] == '0));
endmodule

bind cmd_slot_limiter slot_limiter_chk #(
  .BURST_CYC (BURST_CYC),
  .SLOTS     (SLOTS),
  .HORIZON   (HORIZON),
  .CNT_W     (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_earliest (req_earliest),
  .grant_valid  (grant_valid),
  .grant_cycle  (grant_cycle),
  .grant_window (grant_window),
  .now_i        (now_q),
  .adv_i        (win_adv),
  .cnt_i        (cnt_q)
);

// File: tb/sim_cmd_slot_limiter.sv
`timescale 1ns/1ps
module sim_cmd_slot_limiter;
  import cmd_slot_pkg::*;

  localparam int B  = 4;
  localparam int S  = 3;
  localparam int H  = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [TIME_W-1:0] req_earliest = '0;
  logic [CW-1:0] req_cost = '0;
  logic grant_valid;
  logic [TIME_W-1:0] grant_cycle, grant_window;

  always #2 clk = ~clk;

  cmd_slot_limiter #(.BURST_CYC(B), .SLOTS(S), .HORIZON(H), .COST_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_earliest(req_earliest), .req_cost(req_cost), .grant_valid(grant_valid),
    .grant_cycle(grant_cycle), .grant_window(grant_window));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  longint tb_now = 0;
  int mcnt [longint];
  bit pend = 0;
  longint pw = 0, pc = 0;
  string ptag = "R9";

  always @(posedge clk) begin
    if (!rst_n) tb_now <= 0;
    else        tb_now <= tb_now + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, tb_now);
    end
  endtask

  function automatic bit model_find(input longint now, input longint e, input int cost,
                                    output longint w, output longint issue, output int c);
    longint eff, cur;
    c = (cost == 0) ? 1 : cost;
    w = 0; issue = 0;
    if (c > S) return 0;
    eff = (e < now) ? now : e;
    cur = now / B;
    for (longint x = eff / B; x < cur + H; x++) begin
      int n;
      n = mcnt.exists(x) ? mcnt[x] : 0;
      if (n + c <= S) begin
        w = x;
        issue = (eff > x * B) ? eff : x * B;
        return 1;
      end
    end
    return 0;
  endfunction

  task automatic step(input bit v, input longint e, input int cost, input string tag);
    longint w, iss;
    int c;
    bit ok;
    @(negedge clk);
    if (pend) begin
      chk(grant_valid === 1'b1, ptag, longint'(grant_valid), 1);
      chk(grant_window == TIME_W'(pw), ptag, longint'(grant_window), pw);
      chk(grant_cycle == TIME_W'(pc), ptag, longint'(grant_cycle), pc);
    end else begin
      chk(grant_valid === 1'b0, "R11", longint'(grant_valid), 0);
    end
    req_valid    = v;
    req_earliest = TIME_W'(e);
    req_cost     = CW'(cost);
    #0.5;
    ok = model_find(tb_now, e, cost, w, iss, c);
    chk(req_ready === ok, tag, longint'(req_ready), longint'(ok));
    pend = v && ok;
    ptag = tag;
    if (pend) begin
      pw = w; pc = iss;
      mcnt[w] = (mcnt.exists(w) ? mcnt[w] : 0) + c;
    end
  endtask

  task automatic idle_to_phase(input int ph);
    while (((tb_now + 1) % B) != ph) step(0, 0, 1, "R11");
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    chk(grant_valid === 1'b0, "R1", longint'(grant_valid), 0);
    rst_n = 1'b1;
    // R1: cycle 0, all windows empty: full-cost request fits window 0
    step(0, 0, S, "R1");
    step(1, 0, S, "R1");
    // R6: window 0 is now full, next request defers to window 1
    step(1, 0, 1, "R6");
    // R2: earliest at last cycle of a window vs first of the next
    step(1, 3 * B - 1, 1, "R2");
    step(1, 3 * B, 1, "R2");
    // R6: fill window 4 then chain deferral across windows 4 and 5
    step(1, 4 * B, S, "R6");
    step(1, 5 * B, 2, "R6");
    step(1, 4 * B, 2, "R6");
    // R5: earliest in the past
    idle_to_phase(1);
    step(1, 0, 1, "R5");
    // R7: zero cost counts as one; oversized cost stalls
    step(1, tb_now + 1 + 2 * B, 0, "R7");
    step(1, tb_now + 1 + 2 * B, S - 1, "R7");
    step(1, tb_now + 1 + 2 * B, 1, "R7");
    step(1, tb_now + 1, S + 1, "R7");
    step(1, tb_now + 1, 7, "R7");
    // R8: beyond the horizon stalls
    step(1, tb_now + 1 + H * B, 1, "R8");
    step(1, tb_now + 1 + H * B + 3, 1, "R8");
    step(1, tb_now + 1 + (H - 1) * B, 1, "R8");
    // R10: reservation in the last cycle of a window, next window
    idle_to_phase(B - 1);
    step(1, tb_now + 2, S, "R10");
    step(1, tb_now + 1, 1, "R10");
    idle_to_phase(B - 1);
    step(1, tb_now + 1, 2, "R10");
    step(1, tb_now + 1, 2, "R10");
    // R11: ready without valid reserves nothing
    step(0, tb_now + 1 + B, S, "R11");
    step(0, tb_now + 1 + B, S, "R11");
    step(1, tb_now + 1 + B, S, "R11");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      longint e;
      bit v;
      int c;
      v = ($urandom % 10) < 7;
      e = tb_now + 1 + longint'($urandom % (H * B + 8)) - 4;
      if (e < 0) e = 0;
      c = $urandom % (S + 2);
      step(v, e, c, "R4");
    end
    step(0, 0, 1, "R9");
    step(0, 0, 1, "R9");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule